// File: doc/BRIEF.md
# Segmented Piecewise-Linear Curve Evaluator

This block maps a stream of unsigned fixed-point samples through a transfer curve described as a segmented piecewise-linear table. The input range is cut into up to eight segments. Each segment has its own uniform point spacing: fine near zero and coarse toward full scale. A configuration port loads each segment's start, power-of-two span, point count, base index and flags, and fills a shared entry memory with curve values.

Each accepted sample goes through three stages. The first stage finds the segment that holds the sample and the sample's fractional position inside it. The second stage reads the two neighbouring entries. The third stage blends the two entries, or picks the nearer one, and registers the result. The output is a valid/ready stream. When the consumer stops accepting, the whole pipe freezes.

Input magnitude is 14 bits, and 8192 stands for 1.0. Entries and results are 18 bits. Configure the block while the stream is idle.

Top module: `pwl_lut_eval`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high.
- R2: In a segment without the end-point flag (descriptor bit 36 clear), point i sits at start + i*span/count. An input exactly on a point returns that entry.
- R3: In a segment with the end-point flag (bit 36 set), point spacing is span/(count-1), so the last point lies on the segment end.
- R4: With the blend flag (bit 35) set, the result is (lo*(256-f) + hi*f + 128) >> 8. Here f is the 8-bit fractional position between the lower and upper neighbour.
- R5: With the blend flag clear, the result is the lower entry when f < 128 and the upper entry otherwise.
- R6: For the last point of a segment without the end-point flag, the upper neighbour is the first entry of the next segment.
- R7: For the last active segment, the value at its end is the tail entry, at base+count (flag clear) or base+count-1 (flag set). Any input at or above that end returns the tail entry.
- R8: With mirror mode on (global word bit 3), a negative input is evaluated on its magnitude and the output sign equals the input sign.
- R9: With mirror mode off, a negative input is evaluated as zero and the output sign is positive.
- R10: A sample accepted at one clock edge appears on the output after the second edge that follows. With `out_ready` high, one result leaves per clock.
- R11: While `out_valid` is high and `out_ready` is low, the output holds its value and sign and `in_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | Write target: 0 segment descriptor, 1 entry, 2 global word |
| cfg_addr | input | 8 | Segment number or entry index |
| cfg_data | input | 37 | Descriptor {end-point flag[36], blend[35], base[34:27], count[26:18], log2 span[17:14], start[13:0]}; entry value [17:0]; global {mirror[3], last segment[2:0]} |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample accepted this cycle |
| in_sign | input | 1 | Input sample is negative |
| in_mag | input | 14 | Input sample magnitude |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts result |
| out_sign | output | 1 | Result sign |
| out_value | output | 18 | Result magnitude |

## Verification
A wrong segment pick or a wrong index shows up on the first sample that falls in the affected region. The output takes a neighbouring entry's value, or a blend of the wrong pair, and this appears two edges after the sample is accepted. Samples are placed on points, between points, on the last point of a segment and past the final end, so an off-by-one in spacing or in neighbour choice changes the value at the port. Stall errors show up as a changed, lost or repeated result in the cycles around a release of `out_ready`.

// File: rtl/pwl_lut_pkg.sv
package pwl_lut_pkg;
    localparam int IN_W   = 14;
    localparam int OUT_W  = 18;
    localparam int NSEG   = 8;
    localparam int SEG_W  = $clog2(NSEG);
    localparam int ENT    = 256;
    localparam int ADR_W  = $clog2(ENT);
    localparam int CNT_W  = ADR_W + 1;
    localparam int LG_W   = 4;
    localparam int FRAC_W = 8;
    localparam int CFG_W  = 2 + ADR_W + CNT_W + LG_W + IN_W;
    localparam int PW     = IN_W + CNT_W;
    localparam int SW     = OUT_W + FRAC_W + 1;

    typedef enum logic [1:0] {
        CFG_SEG = 2'd0,
        CFG_ENT = 2'd1,
        CFG_GLB = 2'd2
    } cfg_kind_e;

    typedef struct packed {
        logic               endpt;
        logic               blend;
        logic [ADR_W-1:0]   base;
        logic [CNT_W-1:0]   count;
        logic [LG_W-1:0]    lg;
        logic [IN_W-1:0]    start;
    } seg_t;

    typedef struct packed {
        logic               sign;
        logic               blend;
        logic [ADR_W-1:0]   lo_a;
        logic [ADR_W-1:0]   hi_a;
        logic [FRAC_W-1:0]  frac;
    } s1_t;

    typedef struct packed {
        logic               sign;
        logic               blend;
        logic [OUT_W-1:0]   lo;
        logic [OUT_W-1:0]   hi;
        logic [FRAC_W-1:0]  frac;
    } s2_t;
endpackage

// File: rtl/pwl_seg_search.sv
module pwl_seg_search
    import pwl_lut_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_kind,
    input  logic [ADR_W-1:0] cfg_addr,
    input  logic [CFG_W-1:0] cfg_data,
    input  logic             in_valid,
    input  logic             in_sign,
    input  logic [IN_W-1:0]  in_mag,
    output logic             s1_valid,
    output s1_t              s1
);
    seg_t             seg_q [NSEG];
    logic [SEG_W-1:0] last_q;
    logic             mirror_q;
    logic [3:0]       glb;

    logic [IN_W-1:0]   x;
    logic [SEG_W-1:0]  hit;
    seg_t              cur;
    logic              below, above;
    logic [IN_W:0]     span_end;
    logic [CNT_W-1:0]  n;
    logic [IN_W-1:0]   off;
    logic [PW-1:0]     prod;
    logic [PW+FRAC_W-1:0] pos8;
    logic [ADR_W-1:0]  idx, tail, nxt;
    s1_t               s1_d;

    assign glb = 4'(cfg_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NSEG; k++) seg_q[k] <= '0;
            last_q   <= '0;
            mirror_q <= 1'b0;
        end else if (cfg_we) begin
            if (cfg_kind == CFG_SEG && cfg_addr < ADR_W'(NSEG))
                seg_q[SEG_W'(cfg_addr)] <= seg_t'(cfg_data);
            else if (cfg_kind == CFG_GLB) begin
                last_q   <= glb[SEG_W-1:0];
                mirror_q <= glb[3];
            end
        end
    end

    always_comb begin
        x   = (in_sign && !mirror_q) ? '0 : in_mag;
        hit = '0;
        for (int k = 0; k < NSEG; k++)
            if (SEG_W'(k) <= last_q && x >= seg_q[k].start) hit = SEG_W'(k);
        cur      = seg_q[hit];
        below    = x < seg_q[0].start;
        span_end = {1'b0, cur.start} + ((IN_W+1)'(1) << cur.lg);
        above    = (hit == last_q) && ({1'b0, x} >= span_end);
        n        = cur.endpt ? cur.count - 1'b1 : cur.count;
        off      = x - cur.start;
        prod     = PW'(off) * PW'(n);
        pos8     = {prod, FRAC_W'(0)} >> cur.lg;
        idx      = ADR_W'(pos8 >> FRAC_W);
        tail     = cur.base + ADR_W'(n);
        nxt      = (hit == last_q) ? tail : seg_q[hit + 1'b1].base;

        s1_d.sign  = in_sign & mirror_q;
        s1_d.blend = cur.blend;
        if (below) begin
            s1_d.lo_a = seg_q[0].base;
            s1_d.hi_a = seg_q[0].base;
            s1_d.frac = '0;
        end else if (above) begin
            s1_d.lo_a = tail;
            s1_d.hi_a = tail;
            s1_d.frac = '0;
        end else begin
            s1_d.lo_a = cur.base + idx;
            s1_d.hi_a = (!cur.endpt && {1'b0, idx} == n - 1'b1) ? nxt
                                                                 : cur.base + idx + 1'b1;
            s1_d.frac = pos8[FRAC_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1       <= '0;
        end else if (adv) begin
            s1_valid <= in_valid;
            s1       <= s1_d;
        end
    end

    AST_S1_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !adv |=> ($stable(s1) && $stable(s1_valid))) else $error("s1 moved during stall"); // R11
endmodule

// File: rtl/pwl_entry_fetch.sv
module pwl_entry_fetch
    import pwl_lut_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_kind,
    input  logic [ADR_W-1:0] cfg_addr,
    input  logic [CFG_W-1:0] cfg_data,
    input  logic             s1_valid,
    input  s1_t              s1,
    output logic             s2_valid,
    output s2_t              s2
);
    logic [OUT_W-1:0] mem [ENT];

    always_ff @(posedge clk) begin
        if (cfg_we && cfg_kind == CFG_ENT)
            mem[cfg_addr] <= OUT_W'(cfg_data);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_valid <= 1'b0;
            s2       <= '0;
        end else if (adv) begin
            s2_valid <= s1_valid;
            s2.sign  <= s1.sign;
            s2.blend <= s1.blend;
            s2.lo    <= mem[s1.lo_a];
            s2.hi    <= mem[s1.hi_a];
            s2.frac  <= s1.frac;
        end
    end

    AST_S2_FOLLOWS_S1: assert property (@(posedge clk) disable iff (rst)
        (adv && s1_valid) |=> s2_valid) else $error("stage two lost a sample"); // R10
endmodule

// File: rtl/pwl_interp.sv
module pwl_interp
    import pwl_lut_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic             s2_valid,
    input  s2_t              s2,
    output logic             out_valid,
    output logic             out_sign,
    output logic [OUT_W-1:0] out_value
);
    localparam logic [SW-1:0] MAXV = SW'({OUT_W{1'b1}});

    logic [SW-1:0]    wlo, whi, sum, res;
    logic [OUT_W-1:0] y;

    always_comb begin
        wlo = SW'(s2.lo) * (SW'(1 << FRAC_W) - SW'(s2.frac));
        whi = SW'(s2.hi) * SW'(s2.frac);
        sum = wlo + whi + SW'(1 << (FRAC_W - 1));
        res = sum >> FRAC_W;
        if (s2.blend)
            y = (res > MAXV) ? OUT_W'(MAXV) : OUT_W'(res);
        else
            y = s2.frac[FRAC_W-1] ? s2.hi : s2.lo;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_sign  <= 1'b0;
            out_value <= '0;
        end else if (adv) begin
            out_valid <= s2_valid;
            out_sign  <= s2.sign;
            out_value <= y;
        end
    end

    AST_BLEND_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        $past(adv && s2_valid && s2.blend) |->
            ((out_value >= $past(s2.lo) || out_value >= $past(s2.hi)) &&
             (out_value <= $past(s2.lo) || out_value <= $past(s2.hi))))
        else $error("blend outside neighbours"); // R4
    AST_PICK_NEIGHBOUR: assert property (@(posedge clk) disable iff (rst)
        $past(adv && s2_valid && !s2.blend) |->
            (out_value == $past(s2.lo) || out_value == $past(s2.hi)))
        else $error("pick is not a neighbour"); // R5
endmodule

// File: rtl/pwl_lut_eval.sv
module pwl_lut_eval
    import pwl_lut_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_kind,
    input  logic [ADR_W-1:0] cfg_addr,
    input  logic [CFG_W-1:0] cfg_data,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_sign,
    input  logic [IN_W-1:0]  in_mag,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             out_sign,
    output logic [OUT_W-1:0] out_value
);
    logic adv;
    logic s1_valid, s2_valid;
    s1_t  s1;
    s2_t  s2;

    assign adv      = !out_valid || out_ready;
    assign in_ready = adv;

    pwl_seg_search u_search (
        .clk, .rst, .adv, .cfg_we, .cfg_kind, .cfg_addr, .cfg_data,
        .in_valid, .in_sign, .in_mag, .s1_valid, .s1
    );

    pwl_entry_fetch u_fetch (
        .clk, .rst, .adv, .cfg_we, .cfg_kind, .cfg_addr, .cfg_data,
        .s1_valid, .s1, .s2_valid, .s2
    );

    pwl_interp u_interp (
        .clk, .rst, .adv, .s2_valid, .s2, .out_valid, .out_sign, .out_value
    );

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_value) && $stable(out_sign)))
        else $error("output changed while stalled"); // R11
endmodule

// File: tb/pwl_lut_eval_test.sv
module pwl_lut_eval_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_kind = '0;
    logic [7:0]  cfg_addr = '0;
    logic [36:0] cfg_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        in_sign = 1'b0;
    logic [13:0] in_mag = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic        out_sign;
    logic [17:0] out_value;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pwl_lut_eval uut (.*);

    localparam int NV = 17;
    localparam int V_MAG [NV] = '{0, 256, 128, 100, 800, 1536, 2047, 1535, 2600, 2900,
                                  3900, 5120, 7680, 8192, 9000, 128, 7168};
    localparam int V_NEG [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0};
    localparam int V_EXP [NV] = '{50, 1000, 525, 421, 6500, 15000, 19961, 14961, 30000, 40000,
                                  60000, 100000, 231072, 262143, 262143, 525, 200000};
    // requirement per row: R2 R2 R4 R4 R6 R3 R3 R4 R5 R5 R6 R2 R7 R7 R7 R8 R2
    localparam int V_REQ [NV] = '{2, 2, 4, 4, 6, 3, 3, 4, 5, 5, 6, 2, 7, 7, 7, 8, 2};

    localparam int ENTV [15] = '{50, 1000, 3000, 6000, 10000, 20000, 25000, 30000,
                                 40000, 50000, 60000, 100000, 150000, 200000, 262143};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg(input logic [1:0] k, input int a, input logic [36:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_kind = k; cfg_addr = 8'(a); cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [36:0] seg(input int st, input int lg, input int cnt,
                                        input int base, input bit bl, input bit ep);
        return {ep, bl, 8'(base), 9'(cnt), 4'(lg), 14'(st)};
    endfunction

    task automatic run_one(input int mag, input int neg, output int val, output int sg, output int vld);
        @(negedge clk);
        in_valid = 1'b1; in_mag = 14'(mag); in_sign = neg[0];
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        val = int'(out_value); sg = int'(out_sign); vld = int'(out_valid);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int v, s, vl;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);

        cfg(2'd0, 0, seg(0,    10, 4, 0,  1'b1, 1'b0));
        cfg(2'd0, 1, seg(1024, 10, 2, 4,  1'b1, 1'b1));
        cfg(2'd0, 2, seg(2048, 11, 4, 6,  1'b0, 1'b0));
        cfg(2'd0, 3, seg(4096, 12, 4, 10, 1'b1, 1'b0));
        for (int i = 0; i < 15; i++) cfg(2'd1, i, 37'(ENTV[i]));
        cfg(2'd2, 0, 37'h0B);

        for (int i = 0; i < NV; i++) begin
            run_one(V_MAG[i], V_NEG[i], v, s, vl);
            check(vl == 1 && v == V_EXP[i] && s == V_NEG[i],
                  $sformatf("R%0d vector %0d", V_REQ[i], i), v, V_EXP[i]);
        end

        // R10: back-to-back samples, one result per clock
        @(negedge clk);
        in_valid = 1'b1; in_sign = 1'b0; in_mag = 14'd0;
        @(posedge clk); @(negedge clk);
        in_mag = 14'd256;
        @(posedge clk); @(negedge clk);
        in_mag = 14'd5120;
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0;
        check(out_valid && out_value == 18'd50, "R10 first", int'(out_value), 50);
        @(posedge clk); @(negedge clk);
        check(out_valid && out_value == 18'd1000, "R10 second", int'(out_value), 1000);
        @(posedge clk); @(negedge clk);
        check(out_valid && out_value == 18'd100000, "R10 third", int'(out_value), 100000);
        @(posedge clk); @(negedge clk);

        // R11: stall holds the result and blocks input
        out_ready = 1'b0;
        in_valid = 1'b1; in_mag = 14'd128;
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(out_valid && out_value == 18'd525, "R11 held value", int'(out_value), 525);
        check(in_ready == 1'b0, "R11 in_ready low", int'(in_ready), 0);
        out_ready = 1'b1;
        @(posedge clk); @(negedge clk);
        check(out_valid == 1'b0, "R11 drained", int'(out_valid), 0);

        // R9: mirror off, negative input maps to zero with positive sign
        cfg(2'd2, 0, 37'h03);
        run_one(128, 1, v, s, vl);
        check(vl == 1 && v == 50 && s == 0, "R9 mirror off", v, 50);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule